// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits on the controller side of an SDRAM interface, between the command scheduler and the memory command pins. The scheduler presents one command at a time (activate, read, write, precharge, refresh or mode-register load) together with a bank number. The gate raises `cmd_ready` only when every spacing rule between that command and the commands already issued is satisfied. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The scheduler keeps presenting it until then.

All limits are parameters. Analog limits are given in picoseconds and are rounded up to whole clock periods. Small limits that are already counted in clocks are given as cycle counts. Each bank keeps its own down-counters for the activate-to-column delay, the minimum open time, the row cycle, the precharge time and write recovery. It also keeps an open-row age counter. Shared counters cover activate spacing across banks, column-burst spacing, write-to-read turnaround, the refresh cycle and the mode-register delay.

The block tracks which banks hold an open row. It also warns the scheduler, per bank, when a row has been open long enough that its maximum open time is close.

Top module: `sdram_timing_gate`

## Requirements
- R1: After reset, no bank is open, no over-time flag is set, an activate to any bank is ready at once, and a read to any bank is not ready.
- R2: Operation codes on `cmd_op` are 0 = no-op, 1 = activate, 2 = read, 3 = write, 4 = precharge, 5 = refresh, 6 = mode load, 7 = no-op. State changes only on a cycle where valid and ready are both high. A no-op is always ready and changes nothing.
- R3: Reads and writes are ready only to an open bank, and no earlier than ceil(tRCD/tCK) cycles after that bank's activate. This is 3 cycles with the defaults.
- R4: A precharge to an open bank waits ceil(tRAS/tCK) = 8 cycles after its activate. A new activate to a bank waits ceil(tRP/tCK) = 3 cycles after its precharge and ceil(tRC/tCK) = 11 cycles after its previous activate.
- R5: Activates to any two banks are at least ceil(tRRD/tCK) = 2 cycles apart. An activate to an already open bank is never ready.
- R6: A precharge to a bank waits BL/2 + ceil(tWR/tCK) = 5 cycles after a write to that bank.
- R7: Any two reads or writes are at least BL/2 = 2 cycles apart. A read waits BL/2 + tWTR = 4 cycles after any write.
- R8: A read or write with `cmd_auto_pre` = 1 closes its bank at once, so further reads and writes to it are not ready. The next activate to it waits BL/2 + ceil(tRP/tCK) = 5 cycles after an auto-precharge read, and BL/2 + ceil(tWR/tCK) + ceil(tRP/tCK) = 8 cycles after an auto-precharge write, and never less than the row cycle.
- R9: A precharge with `cmd_auto_pre` = 1 targets all banks and waits until every open bank meets its own precharge rules. A precharge to an idle bank is accepted, leaves the bank idle and starts no precharge timer.
- R10: Refresh and mode load are ready only when every bank is closed and past its precharge time. After a mode load, every command other than a no-op waits tMRD = 2 cycles. After a refresh, every such command waits ceil(tRFC/tCK) = 14 cycles.
- R11: `row_overtime[b]` is high while bank b is open and at least ceil(tRASmax/tCK) - ROW_WARN_CYC = 13936 cycles have passed since its activate. It clears in the cycle after the bank is precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Scheduler presents a command |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_bank | input | BANK_W (2) | Target bank |
| cmd_auto_pre | input | 1 | Read/write: auto-precharge; precharge: all banks |
| cmd_ready | output | 1 | Presented command meets every timing rule (combinational) |
| bank_open | output | NUM_BANKS (4) | Bank holds an open row |
| row_overtime | output | NUM_BANKS (4) | Bank open row nearing its maximum open time |

## Verification
A command accepted in cycle t loads a down-counter. The counter allows the follow-on command in cycle t+N, where N is the rounded limit, so `cmd_ready` for that follow-on is low in cycles t+1 through t+N-1 and high in t+N. Each directed task therefore probes `cmd_ready` in the middle of every cycle right after an acceptance and counts cycles until it rises. That count is compared with a value the bench derives from the nanosecond limits by its own rounding. Sequences are arranged so that a single rule is the binding one in each measurement. `bank_open` and `row_overtime` are registered and are checked in the cycle after the edge that changes them.

// File: rtl/sdram_tg_pkg.sv
package sdram_tg_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5,
    OP_MRS  = 3'd6,
    OP_NOP2 = 3'd7
  } tg_op_e;

  // Whole clock periods covering a limit, rounding up.
  function automatic int cyc_ceil(input int lim_ps, input int clk_ps);
    return (lim_ps + clk_ps - 1) / clk_ps;
  endfunction

  // Counter load so that the follow-on command becomes legal n cycles later.
  function automatic int hold_len(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_tg_bank.sv
module sdram_tg_bank #(
  parameter int CW      = 5,
  parameter int AW      = 14,
  parameter int RCD_L   = 2,
  parameter int RAS_L   = 7,
  parameter int RC_L    = 10,
  parameter int RP_L    = 2,
  parameter int WREC_L  = 4,
  parameter int RDAP_L  = 4,
  parameter int WRAP_L  = 7,
  parameter int OT_AGE  = 13935,
  parameter int AGE_MAX = 14000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic pre_i,
  input  logic ap_i,
  output logic open_o,
  output logic act_ok_o,
  output logic col_ok_o,
  output logic pre_ok_o,
  output logic idle_o,
  output logic overtime_o
);

  localparam logic [CW-1:0] RCD_V  = CW'(RCD_L);
  localparam logic [CW-1:0] RAS_V  = CW'(RAS_L);
  localparam logic [CW-1:0] RC_V   = CW'(RC_L);
  localparam logic [CW-1:0] RP_V   = CW'(RP_L);
  localparam logic [CW-1:0] WREC_V = CW'(WREC_L);
  localparam logic [CW-1:0] RDAP_V = CW'(RDAP_L);
  localparam logic [CW-1:0] WRAP_V = CW'(WRAP_L);
  localparam logic [AW-1:0] OT_V   = AW'(OT_AGE);
  localparam logic [AW-1:0] AMAX_V = AW'(AGE_MAX);

  logic          open_q;
  logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q;
  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
      age_q  <= '0;
    end else begin
      rcd_q <= (rcd_q == '0) ? rcd_q : rcd_q - 1'b1;
      ras_q <= (ras_q == '0) ? ras_q : ras_q - 1'b1;
      rc_q  <= (rc_q  == '0) ? rc_q  : rc_q  - 1'b1;
      rp_q  <= (rp_q  == '0) ? rp_q  : rp_q  - 1'b1;
      wr_q  <= (wr_q  == '0) ? wr_q  : wr_q  - 1'b1;
      if (open_q && age_q != AMAX_V) age_q <= age_q + 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        rcd_q  <= RCD_V;
        ras_q  <= RAS_V;
        rc_q   <= RC_V;
        age_q  <= '0;
      end
      if (rd_i && ap_i) begin
        open_q <= 1'b0;
        rp_q   <= RDAP_V;
      end
      if (wr_i) begin
        wr_q <= WREC_V;
        if (ap_i) begin
          open_q <= 1'b0;
          rp_q   <= WRAP_V;
        end
      end
      if (pre_i && open_q) begin
        open_q <= 1'b0;
        rp_q   <= RP_V;
      end
    end
  end

  assign open_o     = open_q;
  assign act_ok_o   = !open_q && (rp_q == '0) && (rc_q == '0);
  assign col_ok_o   = open_q && (rcd_q == '0);
  assign pre_ok_o   = !open_q || ((ras_q == '0) && (wr_q == '0));
  assign idle_o     = !open_q && (rp_q == '0);
  assign overtime_o = open_q && (age_q >= OT_V);

  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i || wr_i) |-> (open_q && rcd_q == '0)); // R3
  AST_ACT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && rp_q == '0 && rc_q == '0)); // R4
  AST_PRE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_q) |-> (ras_q == '0 && wr_q == '0)); // R6
  AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_i || wr_i) && ap_i) |=> !open_o); // R8
  AST_FRESH_ROW_NOT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (OT_AGE > 0 && act_i) |=> !overtime_o); // R11

endmodule

// File: rtl/sdram_tg_global.sv
module sdram_tg_global #(
  parameter int CW    = 5,
  parameter int RRD_L = 1,
  parameter int COL_L = 1,
  parameter int WTR_L = 3,
  parameter int MRD_L = 1,
  parameter int RFC_L = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic pre_i,
  input  logic ref_i,
  input  logic mrs_i,
  output logic act_ok_o,
  output logic rd_ok_o,
  output logic wr_ok_o,
  output logic any_ok_o
);

  localparam logic [CW-1:0] RRD_V = CW'(RRD_L);
  localparam logic [CW-1:0] COL_V = CW'(COL_L);
  localparam logic [CW-1:0] WTR_V = CW'(WTR_L);
  localparam logic [CW-1:0] MRD_V = CW'(MRD_L);
  localparam logic [CW-1:0] RFC_V = CW'(RFC_L);

  logic [CW-1:0] rrd_q, col_q, wtr_q, mrd_q, rfc_q;
  logic          busy_cmd;

  assign busy_cmd = act_i || rd_i || wr_i || pre_i || ref_i || mrs_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q <= '0;
      col_q <= '0;
      wtr_q <= '0;
      mrd_q <= '0;
      rfc_q <= '0;
    end else begin
      rrd_q <= (rrd_q == '0) ? rrd_q : rrd_q - 1'b1;
      col_q <= (col_q == '0) ? col_q : col_q - 1'b1;
      wtr_q <= (wtr_q == '0) ? wtr_q : wtr_q - 1'b1;
      mrd_q <= (mrd_q == '0) ? mrd_q : mrd_q - 1'b1;
      rfc_q <= (rfc_q == '0) ? rfc_q : rfc_q - 1'b1;
      if (act_i) rrd_q <= RRD_V;
      if (rd_i || wr_i) col_q <= COL_V;
      if (wr_i) wtr_q <= WTR_V;
      if (mrs_i) mrd_q <= MRD_V;
      if (ref_i) rfc_q <= RFC_V;
    end
  end

  assign act_ok_o = (rrd_q == '0);
  assign wr_ok_o  = (col_q == '0);
  assign rd_ok_o  = (col_q == '0) && (wtr_q == '0);
  assign any_ok_o = (mrd_q == '0) && (rfc_q == '0);

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (RRD_L > 0 && act_i) |=> !act_i); // R5
  AST_WRITE_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (WTR_L > 0 && wr_i) |=> !rd_i); // R7
  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (MRD_L > 0 && mrs_i) |=> !busy_cmd); // R10
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (RFC_L > 0 && ref_i) |=> !busy_cmd); // R10

endmodule

// File: rtl/sdram_timing_gate.sv
module sdram_timing_gate #(
  parameter int NUM_BANKS    = 4,
  parameter int CLK_PS       = 5000,
  parameter int T_RCD_PS     = 15000,
  parameter int T_RP_PS      = 15000,
  parameter int T_RAS_PS     = 40000,
  parameter int T_RC_PS      = 55000,
  parameter int T_RRD_PS     = 10000,
  parameter int T_WR_PS      = 15000,
  parameter int T_RFC_PS     = 70000,
  parameter int T_RASMAX_PS  = 70000000,
  parameter int T_WTR_CYC    = 2,
  parameter int T_MRD_CYC    = 2,
  parameter int BURST_LEN    = 4,
  parameter int ROW_WARN_CYC = 64,
  localparam int BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_auto_pre,
  output logic                 cmd_ready,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] row_overtime
);
  import sdram_tg_pkg::*;

  localparam int COL_C  = BURST_LEN / 2;
  localparam int RCD_C  = cyc_ceil(T_RCD_PS, CLK_PS);
  localparam int RP_C   = cyc_ceil(T_RP_PS, CLK_PS);
  localparam int RAS_C  = cyc_ceil(T_RAS_PS, CLK_PS);
  localparam int RC_C   = cyc_ceil(T_RC_PS, CLK_PS);
  localparam int RRD_C  = cyc_ceil(T_RRD_PS, CLK_PS);
  localparam int WR_C   = cyc_ceil(T_WR_PS, CLK_PS);
  localparam int RFC_C  = cyc_ceil(T_RFC_PS, CLK_PS);
  localparam int RMAX_C = cyc_ceil(T_RASMAX_PS, CLK_PS);
  localparam int WREC_C = COL_C + WR_C;
  localparam int RDAP_C = COL_C + RP_C;
  localparam int WRAP_C = COL_C + WR_C + RP_C;
  localparam int WTR_C  = COL_C + T_WTR_CYC;
  localparam int MAX_C  = imax(imax(imax(RCD_C, RAS_C), imax(RC_C, RFC_C)),
                               imax(imax(WRAP_C, WTR_C), imax(RRD_C, T_MRD_CYC)));
  localparam int CW     = $clog2(MAX_C + 1);
  localparam int AW     = $clog2(RMAX_C + 1);
  localparam int OT_AGE = RMAX_C - ROW_WARN_CYC - 1;

  tg_op_e op;
  logic   accept;
  logic   acc_act, acc_rd, acc_wr, acc_pre, acc_ref, acc_mrs;
  logic [NUM_BANKS-1:0] act_hit, rd_hit, wr_hit, pre_hit;
  logic [NUM_BANKS-1:0] b_act_ok, b_col_ok, b_pre_ok, b_idle;
  logic   g_act_ok, g_rd_ok, g_wr_ok, g_any_ok;

  assign op      = tg_op_e'(cmd_op);
  assign accept  = cmd_valid && cmd_ready;
  assign acc_act = accept && op == OP_ACT;
  assign acc_rd  = accept && op == OP_RD;
  assign acc_wr  = accept && op == OP_WR;
  assign acc_pre = accept && op == OP_PRE;
  assign acc_ref = accept && op == OP_REF;
  assign acc_mrs = accept && op == OP_MRS;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel        = (cmd_bank == BANK_W'(b));
    assign act_hit[b] = acc_act && sel;
    assign rd_hit[b]  = acc_rd && sel;
    assign wr_hit[b]  = acc_wr && sel;
    assign pre_hit[b] = acc_pre && (sel || cmd_auto_pre);

    sdram_tg_bank #(
      .CW(CW), .AW(AW),
      .RCD_L(hold_len(RCD_C)), .RAS_L(hold_len(RAS_C)), .RC_L(hold_len(RC_C)),
      .RP_L(hold_len(RP_C)), .WREC_L(hold_len(WREC_C)),
      .RDAP_L(hold_len(RDAP_C)), .WRAP_L(hold_len(WRAP_C)),
      .OT_AGE(OT_AGE), .AGE_MAX(RMAX_C)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_hit[b]), .rd_i(rd_hit[b]), .wr_i(wr_hit[b]),
      .pre_i(pre_hit[b]), .ap_i(cmd_auto_pre),
      .open_o(bank_open[b]), .act_ok_o(b_act_ok[b]), .col_ok_o(b_col_ok[b]),
      .pre_ok_o(b_pre_ok[b]), .idle_o(b_idle[b]), .overtime_o(row_overtime[b])
    );
  end

  sdram_tg_global #(
    .CW(CW), .RRD_L(hold_len(RRD_C)), .COL_L(hold_len(COL_C)),
    .WTR_L(hold_len(WTR_C)), .MRD_L(hold_len(T_MRD_CYC)), .RFC_L(hold_len(RFC_C))
  ) u_global (
    .clk(clk), .rst_n(rst_n),
    .act_i(acc_act), .rd_i(acc_rd), .wr_i(acc_wr), .pre_i(acc_pre),
    .ref_i(acc_ref), .mrs_i(acc_mrs),
    .act_ok_o(g_act_ok), .rd_ok_o(g_rd_ok), .wr_ok_o(g_wr_ok), .any_ok_o(g_any_ok)
  );

  always_comb begin
    unique case (op)
      OP_ACT:  cmd_ready = g_any_ok && g_act_ok && b_act_ok[cmd_bank];
      OP_RD:   cmd_ready = g_any_ok && g_rd_ok && b_col_ok[cmd_bank];
      OP_WR:   cmd_ready = g_any_ok && g_wr_ok && b_col_ok[cmd_bank];
      OP_PRE:  cmd_ready = g_any_ok && (cmd_auto_pre ? (&b_pre_ok) : b_pre_ok[cmd_bank]);
      OP_REF,
      OP_MRS:  cmd_ready = g_any_ok && (&b_idle);
      default: cmd_ready = 1'b1;
    endcase
  end

  AST_ONE_ROW_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_hit)); // R2
  AST_NO_COL_TO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) |-> bank_open[cmd_bank]); // R3
  AST_IDLE_FOR_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ref || acc_mrs) |-> (bank_open == '0)); // R10
  AST_OVERTIME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit != '0) |=> ((row_overtime & $past(pre_hit)) == '0)); // R11

endmodule

// File: tb/sdram_timing_gate_tb_top.sv
`timescale 1ns/1ps
module sdram_timing_gate_tb_top;

  localparam bit [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                       PRE = 3'd4, REF = 3'd5, MRS = 3'd6, NOP7 = 3'd7;
  localparam real TCK = 5.0;
  localparam int E_RCD  = int'($ceil(15.0 / TCK));
  localparam int E_RP   = int'($ceil(15.0 / TCK));
  localparam int E_RAS  = int'($ceil(40.0 / TCK));
  localparam int E_RC   = int'($ceil(55.0 / TCK));
  localparam int E_RRD  = int'($ceil(10.0 / TCK));
  localparam int E_WR   = int'($ceil(15.0 / TCK));
  localparam int E_RFC  = int'($ceil(70.0 / TCK));
  localparam int E_HALF = 4 / 2;
  localparam int E_OT   = int'($ceil(70000.0 / TCK)) - 64;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, cmd_auto_pre, cmd_ready;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [3:0] bank_open, row_overtime;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_timing_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_auto_pre(cmd_auto_pre), .cmd_ready(cmd_ready),
    .bank_open(bank_open), .row_overtime(row_overtime)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(bit [2:0] op, int bank, bit ap, bit v);
    cmd_op = op;
    cmd_bank = 2'(bank);
    cmd_auto_pre = ap;
    cmd_valid = v;
  endtask

  task automatic probe(bit [2:0] op, int bank, bit ap, output bit r);
    drive(op, bank, ap, 1'b0);
    #0.25;
    r = cmd_ready;
  endtask

  task automatic fire(string req, bit [2:0] op, int bank, bit ap);
    drive(op, bank, ap, 1'b1);
    #0.25;
    chk({req, " ready at issue"}, int'(cmd_ready), 1);
    tick();
    cmd_valid = 1'b0;
  endtask

  // Cycles from the last acceptance until the probed command becomes ready.
  task automatic measure(bit [2:0] op, int bank, bit ap, output int g);
    bit r;
    g = 1;
    probe(op, bank, ap, r);
    while (!r && g < 64) begin
      tick();
      g++;
      probe(op, bank, ap, r);
    end
  endtask

  task automatic do_reset();
    drive(NOP, 0, 1'b0, 1'b0);
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    bit r;
    do_reset();
    chk("R1 bank_open", int'(bank_open), 0);
    chk("R1 row_overtime", int'(row_overtime), 0);
    probe(ACT, 2, 1'b0, r);
    chk("R1 activate ready", int'(r), 1);
    probe(RD, 0, 1'b0, r);
    chk("R1 read not ready", int'(r), 0);
  endtask

  task automatic t_handshake();
    bit r;
    do_reset();
    drive(ACT, 1, 1'b0, 1'b0);
    tick();
    chk("R2 no accept without valid", int'(bank_open), 0);
    fire("R2 code 7", NOP7, 1, 1'b0);
    chk("R2 no-op leaves state", int'(bank_open), 0);
    probe(ACT, 1, 1'b0, r);
    chk("R2 activate still ready", int'(r), 1);
  endtask

  task automatic t_rcd();
    int g;
    bit r;
    do_reset();
    fire("R3", ACT, 0, 1'b0);
    chk("R3 bank opened", int'(bank_open), 1);
    probe(WR, 1, 1'b0, r);
    chk("R3 write to closed bank", int'(r), 0);
    measure(RD, 0, 1'b0, g);
    chk("R3 activate to read", g, E_RCD);
  endtask

  task automatic t_ras_rp_rc();
    int g;
    do_reset();
    fire("R4", ACT, 0, 1'b0);
    measure(PRE, 0, 1'b0, g);
    chk("R4 activate to precharge", g, E_RAS);
    tick();
    tick();
    fire("R4", PRE, 0, 1'b0);
    measure(ACT, 0, 1'b0, g);
    chk("R4 precharge to activate", g, E_RP);
    // Row cycle binds: auto-precharge read releases the bank early.
    fire("R4", ACT, 0, 1'b0);
    tick();
    tick();
    fire("R4", RD, 0, 1'b1);
    measure(ACT, 0, 1'b0, g);
    chk("R4 row cycle after read auto-precharge", g, E_RC - E_RCD);
  endtask

  task automatic t_rrd();
    int g;
    bit r;
    do_reset();
    fire("R5", ACT, 0, 1'b0);
    probe(ACT, 0, 1'b0, r);
    chk("R5 activate to open bank", int'(r), 0);
    measure(ACT, 1, 1'b0, g);
    chk("R5 activate spacing", g, E_RRD);
  endtask

  task automatic t_wr_pre();
    int g;
    do_reset();
    fire("R6", ACT, 0, 1'b0);
    repeat (5) tick();
    fire("R6", WR, 0, 1'b0);
    measure(PRE, 0, 1'b0, g);
    chk("R6 write recovery", g, E_HALF + E_WR);
  endtask

  task automatic t_col_wtr();
    int g;
    do_reset();
    fire("R7", ACT, 0, 1'b0);
    tick();
    fire("R7", ACT, 1, 1'b0);
    tick();
    tick();
    fire("R7", WR, 0, 1'b0);
    measure(WR, 1, 1'b0, g);
    chk("R7 write to write", g, E_HALF);
    fire("R7", WR, 1, 1'b0);
    measure(RD, 0, 1'b0, g);
    chk("R7 write to read", g, E_HALF + 2);
    fire("R7", RD, 0, 1'b0);
    measure(RD, 1, 1'b0, g);
    chk("R7 read to read", g, E_HALF);
  endtask

  task automatic t_autopre();
    int g;
    bit r;
    do_reset();
    fire("R8", ACT, 0, 1'b0);
    repeat (4) tick();
    fire("R8", WR, 0, 1'b1);
    chk("R8 write auto-precharge closes", int'(bank_open), 0);
    probe(RD, 0, 1'b0, r);
    chk("R8 read after auto-precharge", int'(r), 0);
    measure(ACT, 0, 1'b0, g);
    chk("R8 write auto-precharge to activate", g, E_HALF + E_WR + E_RP);
    fire("R8", ACT, 0, 1'b0);
    repeat (E_RC + 1) tick();
    fire("R8", RD, 0, 1'b1);
    measure(ACT, 0, 1'b0, g);
    chk("R8 read auto-precharge to activate", g, E_HALF + E_RP);
  endtask

  task automatic t_pre_all();
    int g;
    bit r;
    do_reset();
    fire("R9", ACT, 0, 1'b0);
    tick();
    fire("R9", ACT, 1, 1'b0);
    measure(PRE, 0, 1'b1, g);
    chk("R9 all-bank precharge waits for youngest", g, E_RAS);
    fire("R9", PRE, 0, 1'b1);
    chk("R9 all banks closed", int'(bank_open), 0);
    fire("R9", PRE, 2, 1'b0);
    chk("R9 idle precharge no change", int'(bank_open), 0);
    probe(ACT, 2, 1'b0, r);
    chk("R9 idle precharge starts no timer", int'(r), 1);
    probe(ACT, 0, 1'b0, r);
    chk("R9 precharged bank waits", int'(r), 0);
  endtask

  task automatic t_ref_mrs();
    int g;
    bit r;
    do_reset();
    fire("R10", ACT, 0, 1'b0);
    probe(REF, 0, 1'b0, r);
    chk("R10 refresh with open bank", int'(r), 0);
    probe(MRS, 0, 1'b0, r);
    chk("R10 mode load with open bank", int'(r), 0);
    repeat (E_RAS - 1) tick();
    fire("R10", PRE, 0, 1'b0);
    measure(REF, 0, 1'b0, g);
    chk("R10 refresh waits for precharge", g, E_RP);
    fire("R10", REF, 0, 1'b0);
    measure(ACT, 0, 1'b0, g);
    chk("R10 refresh cycle", g, E_RFC);
    fire("R10", MRS, 0, 1'b0);
    probe(NOP, 0, 1'b0, r);
    chk("R2 no-op ready after mode load", int'(r), 1);
    measure(ACT, 0, 1'b0, g);
    chk("R10 mode load delay", g, 2);
  endtask

  task automatic t_overtime();
    do_reset();
    fire("R11", ACT, 3, 1'b0);
    repeat (E_OT - 2) tick();
    chk("R11 not yet over time", int'(row_overtime), 0);
    tick();
    chk("R11 over time flag", int'(row_overtime), 8);
    fire("R11", PRE, 3, 1'b0);
    chk("R11 cleared by precharge", int'(row_overtime), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    drive(NOP, 0, 1'b0, 1'b0);
    rst_n = 1'b0;
    t_reset();
    t_handshake();
    t_rcd();
    t_ras_rp_rc();
    t_rrd();
    t_wr_pre();
    t_col_wtr();
    t_autopre();
    t_pre_all();
    t_ref_mrs();
    t_overtime();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule